// File: doc/BRIEF.md
# Reset-Time Configuration Loader

After every reset release this block copies a small set of configuration bytes out of the top of program flash into a bank of volatile registers. It uses a single-byte flash read port and fetches one byte per cycle. Each byte is clipped to the bits its register actually implements before it is stored. Downstream logic and debug readers get the registers through a registered read port that decodes a fixed eight-byte address window. A ready flag tells the rest of the chip when the bank holds the flash image rather than the erased-flash defaults.

Two layouts can be built from the same code. In the full layout all eight registers exist. In the reduced layout the last two registers are absent, read as zero and use no storage. A parameter picks the layout. The upper nibble of every odd (high) flash byte is reserved and never reaches a register. Writing flash and decoding individual option bits are left to other blocks.

Top module: `cfg_loader`

## Requirements
- R1: In the cycle after the first rising edge with `rst` low, `flash_rd` is 1 and `flash_addr` is BASE = 2^FLASH_AW − 8. The address then rises by one per cycle through BASE+7. After that, `flash_rd` stays 0 until the next reset. `flash_rd` is 0 during reset.
- R2: The byte that flash returns for address BASE+k (returned the cycle after the request) is stored in register k. Register k is read at address MAP_BASE+k, and the low three address bits select k.
- R3: Each register stores only its implemented bits, and all other bits read 0. The implemented-bit masks for registers 0..7 are E1h, 04h, C7h, 0Fh, 00h, 01h, C3h and 0Fh.
- R4: Bits 7:4 of odd-indexed flash bytes (registers 1, 3, 5, 7) have no effect on any register.
- R5: `cfg_ready` is 0 during reset and while loading. It becomes 1 after the eleventh rising edge with `rst` low, one cycle after register 7 is written, and stays 1 until the next reset.
- R6: While `cfg_ready` is 0, a read of register k returns its mask value, which is what an erased (all-ones) flash byte would produce.
- R7: `cfg_rdata` updates on the rising edge after `cfg_raddr` is presented. An address outside MAP_BASE..MAP_BASE+7 returns 00h.
- R8: A reset at any point, including part-way through loading, drives `cfg_rdata` to 00h, restores the defaults and restarts the whole load sequence.
- R9: With REDUCED=1, registers 6 and 7 always read 00h, and the other registers behave exactly as in the full layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flash_rd | output | 1 | Flash byte-read request |
| flash_addr | output | FLASH_AW | Flash byte address of the request |
| flash_rdata | input | 8 | Flash byte, valid the cycle after the request |
| cfg_raddr | input | MAP_AW | Register read address |
| cfg_rdata | output | 8 | Registered read data |
| cfg_ready | output | 1 | Bank holds the loaded flash image |

## Verification
The flash request for byte k is due in cycle k+1 after release. Register k changes two edges after its request. Ready rises eleven edges after release. Read data is due one edge after the address. The bench counts rising edges since reset release and samples every output on the falling edge, so each expectation is compared in the cycle where that count puts it. Each read is queued with the edge count at which it was issued, and the monitor pops it only once a later edge has passed, so a result is never compared one cycle early or late. Expected read values are computed from the ready state at issue time, and a reset in the middle of loading is included.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int CFG_N  = 8;
  localparam int CFG_IW = $clog2(CFG_N);

  typedef logic [7:0] cfg_byte_t;

  // Implemented-bit mask of register idx. Odd registers hold the high byte of
  // a flash word, whose upper nibble is reserved and never reaches a register.
  function automatic cfg_byte_t cfg_mask(int unsigned idx, bit reduced);
    cfg_byte_t m;
    case (idx)
      0:       m = 8'hE1;
      1:       m = 8'h04;
      2:       m = 8'hC7;
      3:       m = 8'h0F;
      4:       m = 8'h00;
      5:       m = 8'h01;
      6:       m = 8'hC3;
      7:       m = 8'h0F;
      default: m = 8'h00;
    endcase
    if (reduced && idx >= 6) m = 8'h00;
    if ((idx % 2) == 1) m = m & 8'h0F;
    return m;
  endfunction

endpackage

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
  import cfg_loader_pkg::*;
#(
  parameter int FLASH_AW = 15
) (
  input  logic                clk,
  input  logic                rst,
  output logic                flash_rd,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                wr_en,
  output logic [CFG_IW-1:0]   wr_idx,
  output logic                ready
);

  localparam logic [FLASH_AW-1:0] BASE     = {FLASH_AW{1'b1}} ^ FLASH_AW'(CFG_N - 1);
  localparam logic [CFG_IW-1:0]   LAST_IDX = CFG_IW'(CFG_N - 1);

  typedef enum logic [1:0] {LD_IDLE, LD_FETCH, LD_DONE} ld_state_t;

  ld_state_t            st;
  logic [CFG_IW-1:0]    issue_idx;
  logic                 rd_q;
  logic [FLASH_AW-1:0]  addr_q;
  logic                 cap_vld;
  logic [CFG_IW-1:0]    cap_idx;
  logic                 last_q;
  logic                 ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LD_IDLE;
      issue_idx <= '0;
      rd_q      <= 1'b0;
      addr_q    <= BASE;
      cap_vld   <= 1'b0;
      cap_idx   <= '0;
      last_q    <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      // capture stage: the byte requested this cycle arrives next cycle
      cap_vld <= rd_q;
      cap_idx <= issue_idx;
      last_q  <= cap_vld && (cap_idx == LAST_IDX);
      ready_q <= ready_q | last_q;
      unique case (st)
        LD_IDLE: begin
          st        <= LD_FETCH;
          rd_q      <= 1'b1;
          addr_q    <= BASE;
          issue_idx <= '0;
        end
        LD_FETCH: begin
          if (issue_idx == LAST_IDX) begin
            st   <= LD_DONE;
            rd_q <= 1'b0;
          end else begin
            issue_idx <= issue_idx + 1'b1;
            addr_q    <= addr_q + 1'b1;
          end
        end
        default: rd_q <= 1'b0;
      endcase
    end
  end

  assign flash_rd   = rd_q;
  assign flash_addr = addr_q;
  assign wr_en      = cap_vld;
  assign wr_idx     = cap_idx;
  assign ready      = ready_q;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_loader_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CFG_IW-1:0]     wr_idx,
  input  cfg_byte_t             wr_data,
  output cfg_byte_t [CFG_N-1:0] bank_q
);

  for (genvar i = 0; i < CFG_N; i++) begin : g_reg
    localparam cfg_byte_t MASK = cfg_mask(i, REDUCED);
    if (MASK == 8'h00) begin : g_absent
      assign bank_q[i] = '0;
    end else begin : g_live
      cfg_byte_t r;
      always_ff @(posedge clk) begin
        if (rst)
          r <= MASK;
        else if (wr_en && (wr_idx == CFG_IW'(i)))
          r <= wr_data & MASK;
      end
      assign bank_q[i] = r;
    end
  end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfg_loader_pkg::*;
#(
  parameter int              MAP_AW   = 22,
  parameter logic [MAP_AW-1:0] MAP_BASE = 22'h300000,
  parameter bit              REDUCED  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MAP_AW-1:0]     raddr,
  input  logic                  ready,
  input  cfg_byte_t [CFG_N-1:0] bank_q,
  output cfg_byte_t             rdata
);

  logic              in_win;
  logic [CFG_IW-1:0] sel;
  cfg_byte_t         nxt;

  always_comb begin
    in_win = (raddr[MAP_AW-1:CFG_IW] == MAP_BASE[MAP_AW-1:CFG_IW]);
    sel    = raddr[CFG_IW-1:0];
    if (!in_win)
      nxt = '0;
    else if (ready)
      nxt = bank_q[sel];
    else
      nxt = cfg_mask(32'(sel), REDUCED);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int                FLASH_AW = 15,
  parameter int                MAP_AW   = 22,
  parameter logic [MAP_AW-1:0] MAP_BASE = 22'h300000,
  parameter bit                REDUCED  = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  output logic                flash_rd,
  output logic [FLASH_AW-1:0] flash_addr,
  input  logic [7:0]          flash_rdata,
  input  logic [MAP_AW-1:0]   cfg_raddr,
  output logic [7:0]          cfg_rdata,
  output logic                cfg_ready
);

  logic                  wr_en;
  logic [CFG_IW-1:0]     wr_idx;
  logic                  ready;
  cfg_byte_t [CFG_N-1:0] bank_q;

  cfg_fetch_seq #(.FLASH_AW(FLASH_AW)) u_seq (
    .clk(clk), .rst(rst),
    .flash_rd(flash_rd), .flash_addr(flash_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .ready(ready)
  );

  cfg_reg_bank #(.REDUCED(REDUCED)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(flash_rdata),
    .bank_q(bank_q)
  );

  cfg_read_port #(.MAP_AW(MAP_AW), .MAP_BASE(MAP_BASE), .REDUCED(REDUCED)) u_rd (
    .clk(clk), .rst(rst),
    .raddr(cfg_raddr), .ready(ready), .bank_q(bank_q),
    .rdata(cfg_rdata)
  );

  assign cfg_ready = ready;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int                FLASH_AW = 15,
  parameter int                MAP_AW   = 22,
  parameter logic [MAP_AW-1:0] MAP_BASE = 22'h300000,
  parameter bit                REDUCED  = 1'b0
) (
  input logic                clk,
  input logic                rst,
  input logic                flash_rd,
  input logic [FLASH_AW-1:0] flash_addr,
  input logic [MAP_AW-1:0]   cfg_raddr,
  input logic [7:0]          cfg_rdata,
  input logic                cfg_ready
);

  // R1
  fetch_in_top_chk: assert property (@(posedge clk) disable iff (rst)
    flash_rd |-> (flash_addr[FLASH_AW-1:3] == {(FLASH_AW-3){1'b1}}));

  // R1
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_rd && $past(flash_rd)) |-> (flash_addr == $past(flash_addr) + 1'b1));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> cfg_ready);

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> !flash_rd);

  // R7
  off_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_raddr[MAP_AW-1:3] != MAP_BASE[MAP_AW-1:3]) |=> (cfg_rdata == 8'h00));

  // R6
  early_default_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ready && cfg_raddr == MAP_BASE) |=> (cfg_rdata == 8'hE1));

  // R9
  absent_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (REDUCED && cfg_raddr[MAP_AW-1:1] == MAP_BASE[MAP_AW-1:1] + 3'd3) |=> (cfg_rdata == 8'h00));

endmodule

bind cfg_loader cfg_loader_chk #(
  .FLASH_AW(FLASH_AW), .MAP_AW(MAP_AW), .MAP_BASE(MAP_BASE), .REDUCED(REDUCED)
) u_chk (
  .clk(clk), .rst(rst), .flash_rd(flash_rd), .flash_addr(flash_addr),
  .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .cfg_ready(cfg_ready)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;

  localparam int          FAW  = 15;
  localparam logic [14:0] BASE = 15'h7FF8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [21:0] raddr = 22'h0;

  logic           f_rd, r_rd, ready, ready_r;
  logic [FAW-1:0] f_addr, r_addr;
  logic [7:0]     f_rdata = 8'h00, r_rdata = 8'h00;
  logic [7:0]     rdata, rdata_r;
  logic [7:0]     img [8];

  int vectors = 0;
  int fails   = 0;
  int cyc_cnt = 0;
  int post_cnt = 0;
  logic rst_q = 1'b1;

  cfg_loader #(.FLASH_AW(FAW), .REDUCED(1'b0)) dut (
    .clk(clk), .rst(rst), .flash_rd(f_rd), .flash_addr(f_addr), .flash_rdata(f_rdata),
    .cfg_raddr(raddr), .cfg_rdata(rdata), .cfg_ready(ready));

  cfg_loader #(.FLASH_AW(FAW), .REDUCED(1'b1)) dut_red (
    .clk(clk), .rst(rst), .flash_rd(r_rd), .flash_addr(r_addr), .flash_rdata(r_rdata),
    .cfg_raddr(raddr), .cfg_rdata(rdata_r), .cfg_ready(ready_r));

  // flash models: registered byte read
  always_ff @(posedge clk) begin
    if (f_rd) f_rdata <= (f_addr[FAW-1:3] == '1) ? img[f_addr[2:0]] : 8'h00;
    if (r_rd) r_rdata <= (r_addr[FAW-1:3] == '1) ? img[r_addr[2:0]] : 8'h00;
    cyc_cnt  <= cyc_cnt + 1;
    post_cnt <= rst ? 0 : post_cnt + 1;
    rst_q    <= rst;
  end

  function automatic logic [7:0] tb_mask(int k, bit red);
    logic [7:0] m;
    case (k)
      0: m = 8'hE1; 1: m = 8'h04; 2: m = 8'hC7; 3: m = 8'h0F;
      4: m = 8'h00; 5: m = 8'h01; 6: m = 8'hC3; default: m = 8'h0F;
    endcase
    if (red && k >= 6) m = 8'h00;
    return m;
  endfunction

  function automatic logic [7:0] exp_val(logic [21:0] a, bit red, bit rdy);
    int k;
    if (a[21:3] != 19'h60000) return 8'h00;
    k = int'(a[2:0]);
    return rdy ? (img[k] & tb_mask(k, red)) : tb_mask(k, red);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  int         q_cyc [$];
  logic [7:0] q_exp [$];
  logic [7:0] q_expr [$];
  string      q_tag [$];

  task automatic do_read(logic [21:0] a);
    bit rdy;
    @(negedge clk);
    raddr = a;
    rdy = (post_cnt >= 11);
    q_cyc.push_back(cyc_cnt);
    q_exp.push_back(exp_val(a, 1'b0, rdy));
    q_expr.push_back(exp_val(a, 1'b1, rdy));
    if (a[21:3] != 19'h60000) q_tag.push_back("R7 off-window");
    else if (!rdy)            q_tag.push_back("R6 default");
    else                      q_tag.push_back("R2,R3,R4 loaded");
  endtask

  // monitor: per-cycle port checks and scoreboard pops
  initial begin
    forever begin
      @(negedge clk);
      if (rst_q) begin
        chk("R8 reset flash_rd", 32'(f_rd), 32'd0);
        chk("R5 reset ready", 32'(ready), 32'd0);
        chk("R8 reset rdata", 32'(rdata), 32'd0);
        chk("R9 reset rdata", 32'(rdata_r), 32'd0);
      end else begin
        chk("R1 flash_rd", 32'(f_rd), 32'((post_cnt >= 1) && (post_cnt <= 8)));
        if (post_cnt >= 1 && post_cnt <= 8)
          chk("R1 flash_addr", 32'(f_addr), 32'(BASE) + 32'(post_cnt - 1));
        chk("R5 ready", 32'(ready), 32'(post_cnt >= 11));
      end
      while (q_cyc.size() > 0 && q_cyc[0] < cyc_cnt) begin
        string      t;
        logic [7:0] e, er;
        void'(q_cyc.pop_front());
        e  = q_exp.pop_front();
        er = q_expr.pop_front();
        t  = q_tag.pop_front();
        chk(t, 32'(rdata), 32'(e));
        chk("R9 reduced", 32'(rdata_r), 32'(er));
      end
    end
  end

  task automatic set_img(logic [63:0] v);
    for (int i = 0; i < 8; i++) img[i] = v[8*i +: 8];
  endtask

  task automatic full_load(logic [63:0] v);
    @(negedge clk);
    rst = 1'b1;
    set_img(v);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) do_read(22'h300000 + 22'(i));
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) do_read(22'h300000 + 22'(i));
    do_read(22'h300008);
    do_read(22'h2FFFFF);
    do_read(22'h3FFFFF);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    set_img(64'h0);
    repeat (3) @(negedge clk);
    full_load(64'hF0DE_BC9A_7856_3412);
    full_load(64'h0000_0000_0000_0000);
    full_load(64'h0FF0_3CC3_5AA5_F00F);
    // R8: reset part-way through loading, then reload a new image
    @(negedge clk);
    rst = 1'b1;
    set_img(64'h1111_1111_1111_1111);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    full_load(64'hFFFF_FFFF_FFFF_FFFF);
    full_load(64'h5A3C_96E1_0FF0_7EA5);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule